// File: doc/BRIEF.md
# Change-Driven Edge Trigger and Tick Timestamper

This block sits at the front of a capture path in which all logic shares one system clock. A parallel word of input channels is registered only in a cycle in which a one-cycle sample strobe is high. The strobe works as a clock enable and never as a clock. Each new word is compared with the word already held. If they differ, the block reports an event so that downstream storage can open a new record.

A relative timestamp counts strobes since the last recorded change and stays within 1 to 255. When the count would pass 255, it starts again at 1 and a rollover pulse asks storage for a fresh record. At the same time, an edge trigger watches one channel, chosen by an index input, for a rising or falling transition between successive samples. Once it fires, a sticky flag stays up until capture is disabled.

The enable input marks an active capture. While it is low, the word still tracks the strobe, but the timestamp stays at 1 and the block raises no event, rollover or trigger.

Top module: `chg_trig_stamp`

## Requirements
- R1: `sample_q` takes the value of `din` at a rising clock edge where `strobe` is high, and keeps its value at every other edge.
- R2: `event_p` is high for exactly the one cycle after an edge at which `strobe` and `enable` are high and `din` differs from the held `sample_q`.
- R3: The trigger looks at channel `trig_sel` of the held and the incoming word, on strobe edges only. With `trig_rise`=1 it fires on old 0 → new 1. With `trig_rise`=0 it fires on old 1 → new 0.
- R4: `triggered` becomes 1 in the cycle after a trigger edge. It stays 1 while `enable` stays high, and it reads 0 in the cycle after an edge at which `enable` is low.
- R5: On an enabled strobe with no data change and a timestamp below 255, `stamp` increases by exactly 1.
- R6: On an enabled strobe whose data differs from the held word, `stamp` becomes 1.
- R7: On an enabled strobe with no data change while `stamp` is 255, `stamp` becomes 1 and `roll_p` is high for that one following cycle.
- R8: While `enable` is low, `stamp` is 1 after every edge, and `event_p`, `roll_p` and `triggered` stay 0.
- R9: If a data change lands on the strobe where `stamp` is 255, only `event_p` pulses (not `roll_p`), and `stamp` becomes 1.
- R10: During and right after reset, `sample_q` is 0, `stamp` is 1, and `event_p`, `roll_p` and `triggered` are 0.
- R11: `stamp` never reads 0. `event_p` and `roll_p` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Capture active |
| strobe | input | 1 | One-cycle sample qualifier |
| din | input | CH | Input channels |
| trig_sel | input | SEL_W | Index of the trigger channel |
| trig_rise | input | 1 | 1 = rising edge, 0 = falling edge |
| sample_q | output | CH | Registered sample word |
| stamp | output | 8 | Ticks since last recorded change (1..255) |
| event_p | output | 1 | Data-change pulse |
| roll_p | output | 1 | Timestamp wrap pulse |
| triggered | output | 1 | Sticky trigger status |

## Verification
The hardest case to reach is a data change that arrives on exactly the strobe where the timestamp stands at 255. Here the change and the wrap compete for the single new-record request. Getting there takes 254 consecutive enabled strobes of an unchanging word, counted from the last change. The bench issues that run from a loop and flips one channel on the next strobe. It also runs the same sequence with the word left unchanged, so that the plain wrap is observed as well. A scoreboard model in the bench tracks the held word and the expected count, so the wrap point comes from the model and not from the design.

// File: rtl/cts_pkg.sv
package cts_pkg;
  localparam int STAMP_W = 8;
  typedef logic [STAMP_W-1:0] stamp_t;
  localparam stamp_t STAMP_MIN = stamp_t'(1);
  localparam stamp_t STAMP_MAX = '1;

  // transition of one bit that matches the selected polarity
  function automatic logic edge_hit(input logic was, input logic now, input logic rise);
    return (was != now) && (now == rise);
  endfunction

  function automatic logic stamp_full(input stamp_t s);
    return s == STAMP_MAX;
  endfunction

  function automatic stamp_t stamp_inc(input stamp_t s);
    return s + stamp_t'(1);
  endfunction
endpackage

// File: rtl/cts_sampler.sv
module cts_sampler #(
  parameter int CH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          strobe,
  input  logic [CH-1:0] din,
  output logic [CH-1:0] sample_q,
  output logic          chg_hit,
  output logic          event_p
);
  // change seen on a qualified strobe
  assign chg_hit = strobe && enable && (din != sample_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
      event_p  <= 1'b0;
    end else begin
      event_p <= chg_hit;
      if (strobe) sample_q <= din;
    end
  end

  // R1: no strobe, word unchanged
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(sample_q));
  // R2: an event needs an enabled strobe one cycle earlier
  a_r2_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe && enable) |=> !event_p);
endmodule

// File: rtl/cts_edge_arm.sv
module cts_edge_arm #(
  parameter int CH    = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             strobe,
  input  logic [CH-1:0]    old_word,
  input  logic [CH-1:0]    new_word,
  input  logic [SEL_W-1:0] sel,
  input  logic             rise,
  output logic             edge_seen,
  output logic             triggered
);
  import cts_pkg::*;

  function automatic logic pick(input logic [CH-1:0] w, input logic [SEL_W-1:0] s);
    return (int'(s) < CH) ? w[s] : 1'b0;
  endfunction

  assign edge_seen = enable && strobe &&
                     edge_hit(pick(old_word, sel), pick(new_word, sel), rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         triggered <= 1'b0;
    else if (!enable)   triggered <= 1'b0;
    else if (edge_seen) triggered <= 1'b1;
  end

  // R4: sticky while capture stays enabled
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && triggered) |=> triggered);
  // R4 / R8: disable clears the flag
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !triggered);
endmodule

// File: rtl/cts_stamp.sv
module cts_stamp (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            strobe,
  input  logic            chg_hit,
  output cts_pkg::stamp_t stamp,
  output logic            roll_p
);
  import cts_pkg::*;

  logic wrap_hit;
  assign wrap_hit = enable && strobe && !chg_hit && stamp_full(stamp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp  <= STAMP_MIN;
      roll_p <= 1'b0;
    end else begin
      roll_p <= wrap_hit;
      if (!enable)       stamp <= STAMP_MIN;
      else if (strobe) begin
        if (chg_hit || stamp_full(stamp)) stamp <= STAMP_MIN;
        else                              stamp <= stamp_inc(stamp);
      end
    end
  end

  // R8: idle capture holds the count at one
  a_r8_idle_one: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (stamp == STAMP_MIN));
  // R11: zero is never a valid count
  a_r11_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stamp != '0);
  // R5: plain strobe advances by one
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && strobe && !chg_hit && !stamp_full(stamp)) |=> (stamp == $past(stamp) + stamp_t'(1)));
  // R6: change reloads to one
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    chg_hit |=> (stamp == STAMP_MIN));
endmodule

// File: rtl/chg_trig_stamp.sv
module chg_trig_stamp #(
  parameter  int CH    = 8,
  localparam int SEL_W = (CH > 1) ? $clog2(CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             strobe,
  input  logic [CH-1:0]    din,
  input  logic [SEL_W-1:0] trig_sel,
  input  logic             trig_rise,
  output logic [CH-1:0]    sample_q,
  output logic [7:0]       stamp,
  output logic             event_p,
  output logic             roll_p,
  output logic             triggered
);
  import cts_pkg::*;

  // internal events, named for the checks
  logic   chg_hit;
  logic   edge_seen;
  stamp_t stamp_w;

  cts_sampler #(.CH(CH)) u_sampler (
    .clk(clk), .rst_n(rst_n), .enable(enable), .strobe(strobe), .din(din),
    .sample_q(sample_q), .chg_hit(chg_hit), .event_p(event_p)
  );

  cts_edge_arm #(.CH(CH), .SEL_W(SEL_W)) u_arm (
    .clk(clk), .rst_n(rst_n), .enable(enable), .strobe(strobe),
    .old_word(sample_q), .new_word(din), .sel(trig_sel), .rise(trig_rise),
    .edge_seen(edge_seen), .triggered(triggered)
  );

  cts_stamp u_stamp (
    .clk(clk), .rst_n(rst_n), .enable(enable), .strobe(strobe),
    .chg_hit(chg_hit), .stamp(stamp_w), .roll_p(roll_p)
  );

  assign stamp = stamp_w;

  // R9 / R11: at most one new-record request per cycle
  a_r9_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    !(event_p && roll_p));
  // R3: a trigger edge shows up as the flag next cycle
  a_r3_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> triggered);
endmodule

// File: tb/chg_trig_stamp_tb.sv
module chg_trig_stamp_tb;
  localparam int CH = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          strobe = 1'b0;
  logic [CH-1:0] din = '0;
  logic [2:0]    trig_sel = '0;
  logic          trig_rise = 1'b1;
  logic [CH-1:0] sample_q;
  logic [7:0]    stamp;
  logic          event_p, roll_p, triggered;

  always #2 clk = ~clk;  // 250 MHz

  chg_trig_stamp #(.CH(CH)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .strobe(strobe), .din(din),
    .trig_sel(trig_sel), .trig_rise(trig_rise), .sample_q(sample_q),
    .stamp(stamp), .event_p(event_p), .roll_p(roll_p), .triggered(triggered)
  );

  typedef struct {
    logic [CH-1:0] q;
    logic [7:0]    st;
    logic          ev;
    logic          rl;
    logic          tg;
    string         ctx;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference state
  logic [CH-1:0] m_q = '0;
  logic [7:0]    m_st = 8'd1;
  logic          m_tg = 1'b0;

  task automatic chk(input string req, input longint act, input longint expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // driver: one clock cycle of stimulus plus its expected outcome
  task automatic step(input logic en, input logic stb, input logic [CH-1:0] d,
                      input logic [2:0] sel, input logic rise, input string ctx);
    exp_t e;
    logic chg;
    @(negedge clk);
    enable = en; strobe = stb; din = d; trig_sel = sel; trig_rise = rise;
    chg  = stb && (d != m_q);
    e.ev = en && chg;
    e.rl = en && stb && !chg && (m_st == 8'd255);
    if (!en) m_tg = 1'b0;
    else if (stb && (m_q[sel] != d[sel]) && (d[sel] == rise)) m_tg = 1'b1;
    if (!en)                          m_st = 8'd1;
    else if (stb && (chg || m_st == 8'd255)) m_st = 8'd1;
    else if (stb)                     m_st = m_st + 8'd1;
    if (stb) m_q = d;
    e.q = m_q; e.st = m_st; e.tg = m_tg; e.ctx = ctx;
    exp_q.push_back(e);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        chk({"R1 sample_q ", e.ctx}, sample_q, e.q);
        chk({"R5/R6/R8 stamp ", e.ctx}, stamp, e.st);
        chk({"R2 event_p ", e.ctx}, event_p, e.ev);
        chk({"R7 roll_p ", e.ctx}, roll_p, e.rl);
        chk({"R3/R4 triggered ", e.ctx}, triggered, e.tg);
        chk({"R11 no double request ", e.ctx}, event_p && roll_p, 0);
      end
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [CH-1:0] w;
    // R10: reset values
    repeat (3) @(negedge clk);
    chk("R10 sample_q in reset", sample_q, 0);
    chk("R10 stamp in reset", stamp, 1);
    chk("R10 pulses in reset", {event_p, roll_p, triggered}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 stamp after reset", stamp, 1);
    chk("R10 triggered after reset", triggered, 0);

    // R8: disabled, data changes produce nothing
    step(0, 1, 8'h5A, 3, 1, "R8 idle change");
    step(0, 1, 8'hA5, 3, 1, "R8 idle change2");
    step(0, 0, 8'hFF, 3, 1, "R1 no strobe idle");

    // R5: counting with steady data, gaps between strobes
    w = 8'hA5;
    for (int i = 0; i < 6; i++) begin
      step(1, 1, w, 3, 1, "R5 count");
      step(1, 0, ~w, 3, 1, "R1 hold between strobes");
    end
    // R6 / R2: change reloads, event pulses
    step(1, 1, 8'hA4, 3, 1, "R6 change");
    step(1, 1, 8'hA4, 3, 1, "R5 after change");
    // R3: rising edge on channel 3 (bit3 0 -> 1)
    step(1, 1, 8'hA0, 3, 1, "R3 setup low");
    step(1, 0, 8'hA8, 3, 1, "R3 no strobe no trigger");
    step(1, 1, 8'hA8, 3, 1, "R3 rising fire");
    // R4: sticky through further activity
    step(1, 1, 8'hA0, 3, 1, "R4 sticky");
    step(1, 1, 8'h00, 3, 1, "R4 sticky2");
    // R4: clear on disable
    step(0, 0, 8'h00, 3, 1, "R4 clear");
    // R3: falling edge on channel 5; a rising one must not fire
    step(1, 1, 8'h00, 5, 0, "R3 base");
    step(1, 1, 8'h20, 5, 0, "R3 rising ignored by falling");
    step(1, 1, 8'h00, 5, 0, "R3 falling fire");
    step(0, 0, 8'h00, 5, 0, "R4 clear2");

    // R7: wrap with steady data (stamp 1 -> 255 then 1)
    step(1, 1, 8'h3C, 0, 1, "R7 start");
    for (int i = 0; i < 254; i++) step(1, 1, 8'h3C, 0, 1, "R7 climb");
    step(1, 1, 8'h3C, 0, 1, "R7 wrap");
    step(1, 1, 8'h3C, 0, 1, "R7 after wrap");
    // R9: change lands on the 255 strobe
    for (int i = 0; i < 253; i++) step(1, 1, 8'h3C, 0, 1, "R9 climb");
    step(1, 1, 8'h3D, 0, 1, "R9 change at full");
    step(1, 1, 8'h3D, 0, 1, "R9 after");
    step(0, 0, 8'h3D, 0, 1, "R8 end idle");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule